// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block turns a framed synchronous serial bit stream into parallel words. A one-cycle bit enable from an external clock source marks each serial bit. While the frame signal is high, every marked bit is shifted into a 24-bit register, in either MSB-first or LSB-first order. A counter tracks progress against a programmable word length. When the last bit of a word arrives, the word is aligned to a 24-bit or a 16-bit layout and written to a read-only holding register. A receive-full status is raised at the same time, and an interrupt follows it when enabled.

Two side-channel flag pins are sampled on the first bit of each frame. Each captured value is published as a status bit when its word lands in the holding register. A flag reads as zero unless synchronous mode is on, its pin is set as an input, and the transmitter that shares that pin is off. A host clears the full status by pulsing a read strobe. If a new word arrives while the previous one is still unread, the new word overwrites the old one and an overrun status is set.

The shift engine is a two-state machine. **IDLE** waits for the first bit of a frame. The transition *frame_start* (bit enable with frame high) loads that bit, clears the counter to one, captures the flag pins and enters **SHIFT**. **SHIFT** has three ways out. *bit_next* takes one more bit and stays in SHIFT. *word_done* takes the final bit, writes the holding register and returns to IDLE. *frame_abort* fires whenever the frame signal is low, discards the partial word and returns to IDLE.

Top module: `serial_rx_deser`

## Requirements
- R1: Bits are taken only on clock cycles where both `bit_en` and `fsync` are 1; `bit_en` pulses with `fsync` low never produce a word.
- R2: With `lsb_first`=0 the first received bit is the word's most significant bit; with `lsb_first`=1 it is the least significant bit.
- R3: `word_len` selects the word size: 0=8, 1=12, 2=16, 3=24, 4=32 bits. The word is transferred on the cycle that takes its last bit, and `rx_data` shows it one clock edge later.
- R4: For 32-bit words only the last 24 bits received are kept, treated as a 24-bit word. With MSB-first these are word bits 23..0; with LSB-first they are word bits 31..8.
- R5: With `align16`=0 the word's MSB is placed at `rx_data[23]`. With `align16`=1 it is placed at `rx_data[15]`, and bits below bit 0 are dropped. Every `rx_data` bit not covered by the word reads 0.
- R6: `rx_full` becomes 1 on every load of `rx_data`, and `irq` equals `rx_full` when `irq_en`=1 and is 0 otherwise.
- R7: A `rd_strobe` pulse clears `rx_full` and `overrun`. A load while `rx_full`=1 and no read is pending sets `overrun` and replaces `rx_data`.
- R8: Each flag pin is sampled on the first bit of a frame. `flag0`/`flag1` change only when that frame's word is loaded; later pin changes during the word have no effect.
- R9: `flag0` is forced to 0 unless `sync_mode`=1, `flag0_dir_in`=1 and `tx1_en`=0. `flag1` is forced to 0 unless `sync_mode`=1, `flag1_dir_in`=1 and `tx2_en`=0.
- R10: If `fsync` goes low before the word completes, the partial bits are discarded and the next frame starts a fresh word.
- R11: After reset `rx_data` is 0 and `rx_full`, `overrun`, `irq`, `flag0` and `flag1` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe marking a serial bit |
| fsync | input | 1 | Frame active |
| sdata | input | 1 | Serial data in |
| flag0_pin | input | 1 | Side-channel flag pin 0 |
| flag1_pin | input | 1 | Side-channel flag pin 1 |
| lsb_first | input | 1 | Bit order: 0 MSB first, 1 LSB first |
| word_len | input | 3 | Word length code (R3) |
| align16 | input | 1 | Readout alignment: 0 MSB at bit 23, 1 MSB at bit 15 |
| sync_mode | input | 1 | Synchronous mode enable for flags |
| flag0_dir_in | input | 1 | Flag pin 0 configured as input |
| flag1_dir_in | input | 1 | Flag pin 1 configured as input |
| tx1_en | input | 1 | Transmitter sharing flag pin 0 enabled |
| tx2_en | input | 1 | Transmitter sharing flag pin 1 enabled |
| irq_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Holding register read pulse |
| rx_data | output | 24 | Aligned received word |
| rx_full | output | 1 | New word waiting |
| overrun | output | 1 | Word overwritten before being read |
| flag0 | output | 1 | Captured flag 0 |
| flag1 | output | 1 | Captured flag 1 |
| irq | output | 1 | Receive interrupt |

## Verification
The bench sweeps every word length in both bit orders and both alignments. In the 32-bit case, a design that kept the first 24 bits instead of the last would return the wrong byte window. An alignment shift computed from the raw length instead of the kept length would leak bits into the unused byte. A frame aborted partway through must leave no residue: a counter that survives the abort would end the next word early and misplace every bit. The flag pins are toggled after the first bit and each enable condition is cleared in turn, which exposes capture on the wrong bit and gating that ignores the shared transmitter. Back-to-back words without a read show whether overrun is raised and the newer word kept.

// File: rtl/rx_deser_pkg.sv
package rx_deser_pkg;

    typedef enum logic [2:0] {
        WL_8  = 3'd0,
        WL_12 = 3'd1,
        WL_16 = 3'd2,
        WL_24 = 3'd3,
        WL_32 = 3'd4
    } wlen_e;

    function automatic logic [5:0] wlen_bits(input logic [2:0] code);
        unique case (code)
            WL_8:    return 6'd8;
            WL_12:   return 6'd12;
            WL_16:   return 6'd16;
            WL_24:   return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/rx_shift.sv
module rx_shift #(
    parameter int DATA_W = 24,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              fsync,
    input  logic              sdata,
    input  logic              lsb_first,
    input  logic [CNT_W-1:0]  nbits,
    input  logic [CNT_W-1:0]  kept,
    input  logic              flag0_pin,
    input  logic              flag1_pin,
    output logic              xfer,
    output logic [DATA_W-1:0] word,
    output logic              cap0,
    output logic              cap1
);
    typedef enum logic {S_IDLE, S_SHIFT} st_e;

    st_e               state, state_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic [DATA_W-1:0] sreg, sreg_nx, base;
    logic              take;
    logic [CNT_W-1:0]  rj_shift;

    assign take = bit_en & fsync;

    // A new frame starts from a cleared register.
    assign base     = (state == S_IDLE) ? '0 : sreg;
    assign sreg_nx  = lsb_first ? {sdata, base[DATA_W-1:1]} : {base[DATA_W-2:0], sdata};
    assign rj_shift = CNT_W'(DATA_W) - kept;
    assign word     = lsb_first ? (sreg_nx >> rj_shift) : sreg_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Data path registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            cap0 <= 1'b0;
            cap1 <= 1'b0;
        end else begin
            if (take) sreg <= sreg_nx;
            if (take && state == S_IDLE) begin
                cap0 <= flag0_pin;
                cap1 <= flag1_pin;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        xfer     = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (take) begin                 // frame_start
                    state_nx = S_SHIFT;
                    cnt_nx   = CNT_W'(1);
                end
            end
            S_SHIFT: begin
                if (!fsync) begin               // frame_abort
                    state_nx = S_IDLE;
                    cnt_nx   = '0;
                end else if (bit_en) begin
                    if (cnt == nbits - CNT_W'(1)) begin   // word_done
                        xfer     = 1'b1;
                        state_nx = S_IDLE;
                        cnt_nx   = '0;
                    end else begin              // bit_next
                        cnt_nx = cnt + CNT_W'(1);
                    end
                end
            end
            default: state_nx = S_IDLE;
        endcase
    end
endmodule

// File: rtl/rx_align.sv
module rx_align #(
    parameter int DATA_W = 24,
    parameter int CNT_W  = 6
) (
    input  logic [DATA_W-1:0] word,
    input  logic [CNT_W-1:0]  kept,
    input  logic              align16,
    output logic [DATA_W-1:0] data
);
    localparam int NARROW = DATA_W - 8;

    always_comb begin
        if (!align16)
            data = word << (CNT_W'(DATA_W) - kept);
        else if (kept <= CNT_W'(NARROW))
            data = word << (CNT_W'(NARROW) - kept);
        else
            data = word >> (kept - CNT_W'(NARROW));
    end
endmodule

// File: rtl/rx_hold.sv
module rx_hold #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer,
    input  logic [DATA_W-1:0] data_in,
    input  logic              cap0,
    input  logic              cap1,
    input  logic              en0,
    input  logic              en1,
    input  logic              rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              full,
    output logic              overrun,
    output logic              flag0,
    output logic              flag1
);
    logic f0_q, f1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            full    <= 1'b0;
            overrun <= 1'b0;
            f0_q    <= 1'b0;
            f1_q    <= 1'b0;
        end else begin
            if (xfer) begin
                rx_data <= data_in;
                f0_q    <= cap0 & en0;
                f1_q    <= cap1 & en1;
            end
            full    <= xfer | (full & ~rd);
            overrun <= (xfer & full & ~rd) | (overrun & ~rd);
        end
    end

    assign flag0 = f0_q & en0;
    assign flag1 = f1_q & en1;
endmodule

// File: rtl/serial_rx_deser.sv
module serial_rx_deser
    import rx_deser_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              fsync,
    input  logic              sdata,
    input  logic              flag0_pin,
    input  logic              flag1_pin,
    input  logic              lsb_first,
    input  logic [2:0]        word_len,
    input  logic              align16,
    input  logic              sync_mode,
    input  logic              flag0_dir_in,
    input  logic              flag1_dir_in,
    input  logic              tx1_en,
    input  logic              tx2_en,
    input  logic              irq_en,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              overrun,
    output logic              flag0,
    output logic              flag1,
    output logic              irq
);
    localparam int CNT_W = 6;

    logic [CNT_W-1:0]  nbits, kept;
    logic              xfer, cap0, cap1, en0, en1;
    logic [DATA_W-1:0] word, aligned;

    assign nbits = wlen_bits(word_len);
    assign kept  = (nbits > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : nbits;
    assign en0   = sync_mode & flag0_dir_in & ~tx1_en;
    assign en1   = sync_mode & flag1_dir_in & ~tx2_en;

    rx_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .sdata(sdata),
        .lsb_first(lsb_first), .nbits(nbits), .kept(kept),
        .flag0_pin(flag0_pin), .flag1_pin(flag1_pin),
        .xfer(xfer), .word(word), .cap0(cap0), .cap1(cap1)
    );

    rx_align #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_align (
        .word(word), .kept(kept), .align16(align16), .data(aligned)
    );

    rx_hold #(.DATA_W(DATA_W)) i_hold (
        .clk(clk), .rst_n(rst_n), .xfer(xfer), .data_in(aligned),
        .cap0(cap0), .cap1(cap1), .en0(en0), .en1(en1), .rd(rd_strobe),
        .rx_data(rx_data), .full(rx_full), .overrun(overrun),
        .flag0(flag0), .flag1(flag1)
    );

    assign irq = rx_full & irq_en;
endmodule

// File: rtl/rx_deser_checker.sv
module rx_deser_checker #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              fsync,
    input logic              xfer,
    input logic              align16,
    input logic              rd_strobe,
    input logic              sync_mode,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_full,
    input logic              overrun,
    input logic              flag0,
    input logic              flag1
);
    assert_take_needs_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> (fsync && bit_en));

    assert_load_sets_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> rx_full);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !xfer) |=> (!rx_full && !overrun));

    assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && rx_full && !rd_strobe) |=> overrun);

    assert_data_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(rx_data));

    assert_high_byte_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && align16) |=> (rx_data[DATA_W-1:DATA_W-8] == 8'h00));

    assert_flags_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_mode |-> (!flag0 && !flag1));
endmodule

bind serial_rx_deser rx_deser_checker #(.DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .xfer(xfer),
    .align16(align16), .rd_strobe(rd_strobe), .sync_mode(sync_mode),
    .rx_data(rx_data), .rx_full(rx_full), .overrun(overrun),
    .flag0(flag0), .flag1(flag1)
);

// File: tb/test_serial_rx_deser.sv
module test_serial_rx_deser;
    logic clk = 1'b0, rst_n = 1'b0;
    logic bit_en = 0, fsync = 0, sdata = 0, flag0_pin = 0, flag1_pin = 0;
    logic lsb_first = 0, align16 = 0, sync_mode = 0, flag0_dir_in = 0, flag1_dir_in = 0;
    logic tx1_en = 0, tx2_en = 0, irq_en = 0, rd_strobe = 0;
    logic [2:0]  word_len = 3'd0;
    logic [23:0] rx_data;
    logic rx_full, overrun, flag0, flag1, irq;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    serial_rx_deser i_serial_rx_deser (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .sdata(sdata),
        .flag0_pin(flag0_pin), .flag1_pin(flag1_pin), .lsb_first(lsb_first),
        .word_len(word_len), .align16(align16), .sync_mode(sync_mode),
        .flag0_dir_in(flag0_dir_in), .flag1_dir_in(flag1_dir_in),
        .tx1_en(tx1_en), .tx2_en(tx2_en), .irq_en(irq_en), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_full(rx_full), .overrun(overrun),
        .flag0(flag0), .flag1(flag1), .irq(irq)
    );

    function automatic int len_of(input logic [2:0] code);
        case (code)
            3'd0: return 8;
            3'd1: return 12;
            3'd2: return 16;
            3'd3: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic [23:0] exp_data(input logic [31:0] v, input int n,
                                             input bit lsb, input bit a16);
        logic [31:0] w;
        int k;
        w = (n == 32) ? v : (v & ((32'h1 << n) - 1));
        if (n == 32) begin
            w = lsb ? (w >> 8) : (w & 32'h00FF_FFFF);
            k = 24;
        end else k = n;
        if (!a16)        return 24'(w << (24 - k));
        else if (k <= 16) return 24'(w << (16 - k));
        else             return 24'(w >> (k - 16));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        sdata = b; fsync = 1'b1; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        flag0_pin = 1'($urandom);
        flag1_pin = 1'($urandom);
    endtask

    // Sends nb bits of a word of length n; ends at the negedge after the last bit.
    task automatic send_word(input logic [31:0] v, input int n, input int nb,
                             input logic f0, input logic f1);
        flag0_pin = f0; flag1_pin = f1;
        for (int i = 0; i < nb; i++) begin
            int idx;
            idx = lsb_first ? i : (n - 1 - i);
            send_bit(v[idx]);
        end
    endtask

    task automatic end_frame();
        fsync = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        bit e0, e1, f0, f1;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 rx_data", rx_data, 0);
        check("R11 status", {rx_full, overrun, irq, flag0, flag1}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: bit strobes without frame
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); sdata = 1'($urandom); bit_en = 1'b1;
            @(negedge clk); bit_en = 1'b0;
        end
        check("R1 no word without frame", rx_full, 0);

        // Random words: R2 R3 R4 R5 R6 R8 R9
        for (int t = 0; t < 120; t++) begin
            word_len     = 3'($urandom_range(0, 4));
            lsb_first    = 1'($urandom);
            align16      = 1'($urandom);
            sync_mode    = ($urandom_range(0, 3) != 0);
            flag0_dir_in = ($urandom_range(0, 3) != 0);
            flag1_dir_in = ($urandom_range(0, 3) != 0);
            tx1_en       = ($urandom_range(0, 3) == 0);
            tx2_en       = ($urandom_range(0, 3) == 0);
            irq_en       = 1'($urandom);
            v = $urandom;
            f0 = 1'($urandom); f1 = 1'($urandom);
            n = len_of(word_len);
            e0 = sync_mode && flag0_dir_in && !tx1_en;
            e1 = sync_mode && flag1_dir_in && !tx2_en;
            send_word(v, n, n, f0, f1);
            check($sformatf("R2 R3 R4 R5 data len=%0d lsb=%0d a16=%0d", n, lsb_first, align16),
                  rx_data, exp_data(v, n, lsb_first, align16));
            check("R6 full after load", rx_full, 1);
            check("R6 irq gating", irq, irq_en);
            check("R8 R9 flag0", flag0, f0 & e0);
            check("R8 R9 flag1", flag1, f1 & e1);
            if (t % 2 == 1) end_frame();
            do_read();
            check("R7 read clears full", {rx_full, overrun}, 0);
        end

        // R9: disabling conditions force flags low afterwards
        sync_mode = 1; flag0_dir_in = 1; flag1_dir_in = 1; tx1_en = 0; tx2_en = 0;
        lsb_first = 0; align16 = 0; word_len = 3'd0;
        send_word(32'hA5, 8, 8, 1'b1, 1'b1);
        end_frame();
        check("R8 flags captured", {flag0, flag1}, 2'b11);
        tx1_en = 1; #1;
        check("R9 tx1 blocks flag0", {flag0, flag1}, 2'b01);
        tx1_en = 0; flag1_dir_in = 0; #1;
        check("R9 dir blocks flag1", {flag0, flag1}, 2'b10);
        sync_mode = 0; #1;
        check("R9 sync off", {flag0, flag1}, 2'b00);
        sync_mode = 1; flag1_dir_in = 1;
        do_read();

        // R7: overrun on back-to-back words without read
        word_len = 3'd2;
        send_word(32'h1234, 16, 16, 1'b0, 1'b0);
        end_frame();
        check("R7 no overrun yet", overrun, 0);
        send_word(32'hBEEF, 16, 16, 1'b0, 1'b0);
        end_frame();
        check("R7 overrun set", overrun, 1);
        check("R7 newer word kept", rx_data, exp_data(32'hBEEF, 16, 0, 0));
        do_read();
        check("R7 read clears overrun", {rx_full, overrun}, 0);

        // R10: aborted frame leaves no residue
        word_len = 3'd1; lsb_first = 1;
        send_word(32'hFFF, 12, 7, 1'b1, 1'b1);
        end_frame();
        check("R10 partial not loaded", rx_full, 0);
        send_word(32'h5A3, 12, 12, 1'b0, 1'b0);
        end_frame();
        check("R10 fresh word", rx_data, exp_data(32'h5A3, 12, 1, 0));
        check("R10 flags from new frame", {flag0, flag1}, 2'b00);
        do_read();

        // R4 R5 directed: 32-bit words both orders, narrow alignment
        word_len = 3'd4; align16 = 1;
        lsb_first = 0;
        send_word(32'hDEAD_BEEF, 32, 32, 1'b0, 1'b0);
        end_frame();
        check("R4 R5 msb 32 a16", rx_data, 24'h00_ADBE);
        do_read();
        lsb_first = 1; align16 = 0;
        send_word(32'hDEAD_BEEF, 32, 32, 1'b0, 1'b0);
        end_frame();
        check("R4 lsb 32 keeps high bits", rx_data, 24'hDEADBE);
        do_read();

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule